// File: doc/BRIEF.md
# Multiword DMA Strobe Sequencer

This block runs the device side of a parallel disk-interface multiword DMA transfer. When the attached device raises its DMA request and the enable input is set, the block asserts the acknowledge line. It then issues one 16-bit word cycle after another. Each cycle has three counted phases: a setup phase with acknowledge high and the strobe idle, a strobe phase with the read or write strobe low, and a recovery phase that completes the cycle. Every phase length is an 8-bit clock count. Each attached device has its own set of three counts. The device-select input picks the set, and the choice is frozen when acknowledge rises.

Words reach the block from a transmit stream and leave it on a receive stream, both valid/ready. The transmit side offers a word on `tx_valid`. The block accepts it only at the start of a write cycle (`tx_ready` high for that one decision cycle), so a source with no word stalls the sequence before the strobe. The receive side holds a captured word on `rx_valid` with `rx_data` stable until `rx_ready` is seen high. A read cycle is begun only while `rx_ready` is high, so a sink that cannot take a word holds the strobe off. While stalled, acknowledge stays asserted.

Top module: `mdma_seq`

## Requirements
- R1: After reset, acknowledge is low, both strobes are high (inactive), `dev_dd_oe`, `tx_ready`, `rx_valid` and `xfer_busy` are low.
- R2: Acknowledge rises on the first clock edge at which request and enable are both high. It stays low while either is low.
- R3: The first strobe of a burst goes low exactly setup-count clocks after acknowledge rises, and a strobe is low only while acknowledge is high.
- R4: Each strobe stays low for exactly strobe-count clocks.
- R5: In a burst that is not throttled, acknowledge stays high and the strobe stays high for recovery-count plus setup-count clocks between two consecutive strobes.
- R6: When request or enable is low at the end of a recovery phase, acknowledge falls after exactly recovery-count clocks of strobe-high time.
- R7: A count of zero for any phase behaves as a count of one.
- R8: The timing set is chosen by `dev_sel` (0 selects the lowest slice of each count bus) when acknowledge rises. Changes of `dev_sel` during the burst have no effect on the phase lengths.
- R9: With `dir_wr`=1, each strobe drives the word taken in the most recent transmit handshake on `dev_dd_out` with `dev_dd_oe` high. With no transmit word available, acknowledge stays high, no strobe occurs and `tx_ready` stays high.
- R10: With `dir_wr`=0, the word on `dev_dd_in` at the clock edge where the read strobe rises is presented on `rx_data` with `rx_valid`, held stable until `rx_ready`. No read strobe starts while `rx_ready` is low.
- R11: Only the read strobe pulses for `dir_wr`=0 and only the write strobe for `dir_wr`=1. The two are never low together, and `dev_dd_oe` is low in reads.
- R12: `xfer_busy` equals the acknowledge output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_en | input | 1 | Allows transfers to run |
| dir_wr | input | 1 | 1 = write to device, 0 = read from device |
| dev_sel | input | SW | Selects the timing set, sampled at acknowledge rise |
| tm_cfg | input | NDEV*CW | Setup counts, one CW slice per device |
| td_cfg | input | NDEV*CW | Strobe-low counts, one slice per device |
| teoc_cfg | input | NDEV*CW | Recovery counts, one slice per device |
| dev_dmarq | input | 1 | Device DMA request |
| dev_dmack | output | 1 | DMA acknowledge to device (active high) |
| dev_dior_n | output | 1 | Read strobe, active low |
| dev_diow_n | output | 1 | Write strobe, active low |
| dev_dd_in | input | DW | Data bus from device |
| dev_dd_out | output | DW | Data bus to device |
| dev_dd_oe | output | 1 | Data bus drive enable |
| tx_valid | input | 1 | Transmit word available |
| tx_ready | output | 1 | Transmit word accepted this cycle if valid |
| tx_data | input | DW | Transmit word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Sink can take a word |
| rx_data | output | DW | Received word |
| xfer_busy | output | 1 | Transfer in progress |

## Verification
Acknowledge follows request and enable after one clock edge. After that, every result is due a fixed number of clocks after the previous event: the strobe falls after the setup count, rises after the strobe count, and the next strobe or the release follows after the recovery count (plus the setup count). A monitor samples on the falling clock edge and counts these phases sample by sample, so each length is compared with the count from the requirement and never with a wall-clock time. Transmit and receive words are queued on the handshake or at the strobe edge and compared when they appear on the bus or the receive stream. Throttle cases hold the stall for many cycles and then confirm that no strobe occurred.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GATE,
    ST_SETUP,
    ST_STRB,
    ST_RECOV
  } mdma_st_e;

  function automatic int unsigned sel_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mdma_timing_sel.sv
module mdma_timing_sel #(
  parameter int NDEV = 2,
  parameter int CW   = 8,
  parameter int SW   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic [SW-1:0]     sel,
  input  logic [NDEV*CW-1:0] tm_all,
  input  logic [NDEV*CW-1:0] td_all,
  input  logic [NDEV*CW-1:0] teoc_all,
  output logic [CW-1:0]     tm_eff,
  output logic [CW-1:0]     td_eff,
  output logic [CW-1:0]     teoc_eff
);

  logic [CW-1:0] tm_a   [NDEV];
  logic [CW-1:0] td_a   [NDEV];
  logic [CW-1:0] teoc_a [NDEV];

  for (genvar g = 0; g < NDEV; g++) begin : g_unpack
    assign tm_a[g]   = tm_all[g*CW +: CW];
    assign td_a[g]   = td_all[g*CW +: CW];
    assign teoc_a[g] = teoc_all[g*CW +: CW];
  end

  logic [CW-1:0] tm_live, td_live, teoc_live;
  logic [CW-1:0] tm_held, td_held, teoc_held;

  always_comb begin
    tm_live   = tm_a[0];
    td_live   = td_a[0];
    teoc_live = teoc_a[0];
    for (int i = 0; i < NDEV; i++) begin
      if (int'(sel) == i) begin
        tm_live   = tm_a[i];
        td_live   = td_a[i];
        teoc_live = teoc_a[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tm_held   <= '0;
      td_held   <= '0;
      teoc_held <= '0;
    end else if (idle) begin
      tm_held   <= tm_live;
      td_held   <= td_live;
      teoc_held <= teoc_live;
    end
  end

  assign tm_eff   = idle ? tm_live   : tm_held;
  assign td_eff   = idle ? td_live   : td_held;
  assign teoc_eff = idle ? teoc_live : teoc_held;

  p_held_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !$past(idle)) |-> $stable(tm_held) && $stable(td_held) && $stable(teoc_held));

endmodule

// File: rtl/mdma_phase_cnt.sv
module mdma_phase_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= (load_val == '0) ? '0 : load_val - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

  p_load_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val <= 1) |=> done);

endmodule

// File: rtl/mdma_xfer_dp.sv
module mdma_xfer_dp #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_take,
  input  logic [DW-1:0] tx_data,
  output logic [DW-1:0] dd_out,
  input  logic          rx_cap,
  input  logic [DW-1:0] dd_in,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dd_out <= '0;
    end else if (tx_take) begin
      dd_out <= tx_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (rx_cap) begin
      rx_valid <= 1'b1;
      rx_data  <= dd_in;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  p_rx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid && $stable(rx_data));

  p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_take |=> $stable(dd_out));

endmodule

// File: rtl/mdma_seq.sv
module mdma_seq
  import mdma_pkg::*;
#(
  parameter int NDEV = 2,
  parameter int CW   = 8,
  parameter int DW   = 16,
  localparam int SW  = sel_w(NDEV)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dma_en,
  input  logic               dir_wr,
  input  logic [SW-1:0]      dev_sel,
  input  logic [NDEV*CW-1:0] tm_cfg,
  input  logic [NDEV*CW-1:0] td_cfg,
  input  logic [NDEV*CW-1:0] teoc_cfg,
  input  logic               dev_dmarq,
  output logic               dev_dmack,
  output logic               dev_dior_n,
  output logic               dev_diow_n,
  input  logic [DW-1:0]      dev_dd_in,
  output logic [DW-1:0]      dev_dd_out,
  output logic               dev_dd_oe,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic [DW-1:0]      tx_data,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic [DW-1:0]      rx_data,
  output logic               xfer_busy
);

  mdma_st_e st_q, st_d;
  logic go, idle, dir_q, dir_eff, decide, buf_ok;
  logic cnt_done, cnt_load;
  logic [CW-1:0] cnt_val, tm_e, td_e, teoc_e;
  logic rx_cap, tx_take;

  assign go      = dev_dmarq & dma_en;
  assign idle    = (st_q == ST_IDLE);
  assign dir_eff = idle ? dir_wr : dir_q;
  assign decide  = idle | (st_q == ST_GATE) | ((st_q == ST_RECOV) & cnt_done);
  assign buf_ok  = dir_eff ? tx_valid : rx_ready;
  assign tx_ready = decide & go & dir_eff;
  assign tx_take  = tx_valid & tx_ready;
  assign rx_cap   = (st_q == ST_STRB) & cnt_done & ~dir_q;

  mdma_timing_sel #(.NDEV(NDEV), .CW(CW), .SW(SW)) u_tsel (
    .clk      (clk),
    .rst_n    (rst_n),
    .idle     (idle),
    .sel      (dev_sel),
    .tm_all   (tm_cfg),
    .td_all   (td_cfg),
    .teoc_all (teoc_cfg),
    .tm_eff   (tm_e),
    .td_eff   (td_e),
    .teoc_eff (teoc_e)
  );

  mdma_phase_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .done     (cnt_done)
  );

  mdma_xfer_dp #(.DW(DW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_take  (tx_take),
    .tx_data  (tx_data),
    .dd_out   (dev_dd_out),
    .rx_cap   (rx_cap),
    .dd_in    (dev_dd_in),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data)
  );

  always_comb begin
    st_d     = st_q;
    cnt_load = 1'b0;
    cnt_val  = tm_e;
    if (decide) begin
      if (!go) begin
        st_d = ST_IDLE;
      end else if (buf_ok) begin
        st_d     = ST_SETUP;
        cnt_load = 1'b1;
        cnt_val  = tm_e;
      end else begin
        st_d = ST_GATE;
      end
    end else if (cnt_done) begin
      if (st_q == ST_SETUP) begin
        st_d     = ST_STRB;
        cnt_load = 1'b1;
        cnt_val  = td_e;
      end else if (st_q == ST_STRB) begin
        st_d     = ST_RECOV;
        cnt_load = 1'b1;
        cnt_val  = teoc_e;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      dir_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (idle && go) dir_q <= dir_wr;
    end
  end

  assign dev_dmack  = ~idle;
  assign xfer_busy  = ~idle;
  assign dev_dior_n = ~((st_q == ST_STRB) & ~dir_q);
  assign dev_diow_n = ~((st_q == ST_STRB) &  dir_q);
  assign dev_dd_oe  = ~idle & dir_q;

  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dev_dior_n && !dev_diow_n));

  p_strobe_in_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_dior_n || !dev_diow_n) |-> dev_dmack);

  p_ack_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_dmack) |-> $past(go));

  p_tx_then_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> dev_dd_oe && dev_diow_n);

  p_read_no_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_dior_n |-> !dev_dd_oe);

endmodule

// File: tb/tb_mdma_seq.sv
module tb_mdma_seq;

  localparam int NDEV = 2;
  localparam int CW   = 8;
  localparam int DW   = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic dma_en = 1'b0, dir_wr = 1'b1, dev_sel = 1'b0;
  logic [NDEV*CW-1:0] tm_cfg, td_cfg, teoc_cfg;
  logic dev_dmack, dev_dior_n, dev_diow_n, dev_dd_oe;
  logic [DW-1:0] dev_dd_in = '0, dev_dd_out;
  logic tx_ready, rx_valid, xfer_busy;
  logic rx_ready = 1'b1;
  logic [DW-1:0] rx_data;

  int nstb = 0, stop_at = 0, tx_idx = 0, tx_hs = 0, tx_lim = 0, rd_idx = 0;
  logic req_on = 1'b0, cur_wr = 1'b1, skip_gap = 1'b0;
  int exp_tm = 2, exp_td = 3, exp_teoc = 2;
  int n_chk = 0, n_fail = 0;
  logic finished = 1'b0;

  logic dev_dmarq, tx_valid;
  logic [DW-1:0] tx_data;
  assign dev_dmarq = req_on && (nstb < stop_at);
  assign tx_valid  = (tx_idx < tx_lim);
  assign tx_data   = 16'hA000 + tx_idx[15:0];

  // dev0: setup 2, strobe 3, recovery 2 ; dev1: setup 0 (acts as 1), strobe 4, recovery 3
  assign tm_cfg   = {8'd0, 8'd2};
  assign td_cfg   = {8'd4, 8'd3};
  assign teoc_cfg = {8'd3, 8'd2};

  mdma_seq #(.NDEV(NDEV), .CW(CW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .dir_wr(dir_wr), .dev_sel(dev_sel),
    .tm_cfg(tm_cfg), .td_cfg(td_cfg), .teoc_cfg(teoc_cfg),
    .dev_dmarq(dev_dmarq), .dev_dmack(dev_dmack), .dev_dior_n(dev_dior_n),
    .dev_diow_n(dev_diow_n), .dev_dd_in(dev_dd_in), .dev_dd_out(dev_dd_out),
    .dev_dd_oe(dev_dd_oe), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .xfer_busy(xfer_busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  logic [DW-1:0] q_tx[$];
  logic [DW-1:0] q_rx[$];

  always @(posedge clk) begin
    #1 tx_idx <= tx_hs;
  end

  // monitor / scoreboard
  logic prev_ack = 1'b0, prev_stb = 1'b0, first = 1'b0;
  int hi_cnt = 0, lo_cnt = 0;
  always @(negedge clk) begin
    logic stb;
    logic [DW-1:0] e;
    if (rst_n && !finished) begin
      stb = !dev_dior_n || !dev_diow_n;
      if (tx_valid && tx_ready) begin
        q_tx.push_back(tx_data);
        tx_hs = tx_hs + 1;
      end
      if (rx_valid && rx_ready) begin
        if (q_rx.size() == 0) chk(0, "R10 unexpected rx word", int'(rx_data), 0);
        else begin
          e = q_rx.pop_front();
          chk(rx_data == e, "R10 rx data", int'(rx_data), int'(e));
        end
      end
      if (stb && !prev_stb) begin
        if (first) chk(hi_cnt == exp_tm, "R3 setup length", hi_cnt, exp_tm);
        else if (!skip_gap) chk(hi_cnt == exp_teoc + exp_tm, "R5 strobe spacing", hi_cnt, exp_teoc + exp_tm);
        first = 1'b0;
        lo_cnt = 1;
        nstb <= nstb + 1;
        chk(xfer_busy == dev_dmack, "R12 busy", int'(xfer_busy), int'(dev_dmack));
        if (cur_wr) begin
          chk(dev_dior_n && dev_dd_oe, "R11 write strobe/oe", int'(dev_dior_n), 1);
          if (q_tx.size() == 0) chk(0, "R9 no tx word queued", 0, 1);
          else begin
            e = q_tx.pop_front();
            chk(dev_dd_out == e, "R9 write data", int'(dev_dd_out), int'(e));
          end
        end else begin
          chk(dev_diow_n && !dev_dd_oe, "R11 read strobe/oe", int'(dev_diow_n), 1);
          e = 16'h5000 + rd_idx[15:0];
          rd_idx = rd_idx + 1;
          dev_dd_in <= e;
          q_rx.push_back(e);
        end
      end else if (stb) begin
        lo_cnt = lo_cnt + 1;
      end else if (dev_dmack) begin
        if (!prev_ack) begin hi_cnt = 1; first = 1'b1; end
        else if (prev_stb) begin
          chk(lo_cnt == exp_td, "R4 strobe width", lo_cnt, exp_td);
          hi_cnt = 1;
        end else hi_cnt = hi_cnt + 1;
      end
      if (!dev_dmack && prev_ack)
        chk(hi_cnt == exp_teoc, "R6 release after recovery", hi_cnt, exp_teoc);
      prev_ack = dev_dmack;
      prev_stb = stb;
    end
  end

  task automatic drv();
    @(posedge clk); #1;
  endtask

  task automatic wait_strobes(input int target);
    while (nstb < target) @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (dev_dmack) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!dev_dmack, "R1 dmack", int'(dev_dmack), 0);
    chk(dev_dior_n && dev_diow_n, "R1 strobes", int'({dev_dior_n, dev_diow_n}), 3);
    chk(!dev_dd_oe && !tx_ready && !rx_valid, "R1 oe/tx_ready/rx_valid", int'({dev_dd_oe, tx_ready, rx_valid}), 0);
    chk(!xfer_busy, "R12 busy at reset", int'(xfer_busy), 0);

    // R2: request without enable is ignored; then write burst of 3 words on dev0
    drv();
    dir_wr = 1'b1; cur_wr = 1'b1; tx_lim = 3; stop_at = nstb + 3; req_on = 1'b1;
    repeat (8) @(negedge clk);
    chk(!dev_dmack && !tx_ready, "R2 no ack without enable", int'(dev_dmack), 0);
    drv();
    dma_en = 1'b1;
    @(negedge clk);
    chk(!dev_dmack, "R2 ack not before edge", int'(dev_dmack), 0);
    @(negedge clk);
    chk(dev_dmack, "R2 ack after one edge", int'(dev_dmack), 1);
    wait_idle();
    chk(nstb == 3, "R9 write strobe count", nstb, 3);
    chk(q_tx.size() == 0 && tx_idx == 3, "R9 tx words consumed", tx_idx, 3);

    // R9 throttle: only two words available for a three-word request
    drv();
    skip_gap = 1'b1; base = nstb; tx_lim = tx_idx + 2; stop_at = nstb + 3;
    wait_strobes(base + 2);
    repeat (30) @(negedge clk);
    chk(dev_dmack, "R9 ack held while starved", int'(dev_dmack), 1);
    chk(nstb == base + 2, "R9 no strobe while starved", nstb, base + 2);
    chk(tx_ready, "R9 tx_ready while waiting", int'(tx_ready), 1);
    drv();
    tx_lim = tx_lim + 1;
    wait_idle();
    chk(nstb == base + 3, "R9 resumed word", nstb, base + 3);

    // R8/R7/R10: read burst on dev1, dev_sel changed mid-burst
    drv();
    skip_gap = 1'b0; cur_wr = 1'b0; dir_wr = 1'b0; dev_sel = 1'b1; rx_ready = 1'b1;
    exp_tm = 1; exp_td = 4; exp_teoc = 3;
    base = nstb; stop_at = nstb + 3;
    @(negedge clk);
    while (!dev_dmack) @(negedge clk);
    drv();
    dev_sel = 1'b0;
    wait_idle();
    chk(nstb == base + 3, "R8 read strobe count", nstb, base + 3);
    chk(q_rx.size() == 0, "R10 rx words drained", q_rx.size(), 0);

    // R10 throttle: sink not ready after first read word
    drv();
    skip_gap = 1'b1; exp_tm = 2; exp_td = 3; exp_teoc = 2;
    base = nstb; stop_at = nstb + 2;
    wait_strobes(base + 1);
    drv();
    rx_ready = 1'b0;
    repeat (30) @(negedge clk);
    chk(rx_valid, "R10 rx word held", int'(rx_valid), 1);
    chk(nstb == base + 1, "R10 no read while sink full", nstb, base + 1);
    chk(dev_dmack, "R10 ack held while sink full", int'(dev_dmack), 1);
    drv();
    rx_ready = 1'b1;
    wait_idle();
    chk(nstb == base + 2 && q_rx.size() == 0, "R10 resumed read", nstb, base + 2);

    // R6: enable cleared mid-burst
    drv();
    skip_gap = 1'b0; cur_wr = 1'b1; dir_wr = 1'b1;
    base = nstb; tx_lim = tx_idx + 10; stop_at = nstb + 10;
    wait_strobes(base + 2);
    drv();
    dma_en = 1'b0;
    wait_idle();
    chk(nstb == base + 2, "R6 stop after enable clear", nstb, base + 2);
    chk(q_tx.size() == 0, "R9 tx queue empty", q_tx.size(), 0);
    chk(!tx_ready, "R2 no tx_ready when disabled", int'(tx_ready), 0);

    summary();
  end

endmodule